// File: doc/BRIEF.md
# Serial ADC frame reader

This block is the master side of a three-wire serial link to a successive-approximation converter that has no clock of its own. The converter runs on the serial clock for both sampling and conversion. A single start pulse makes the block pull chip select low and issue one read frame of 22 serial clocks. The first five clocks let the converter acquire its input. The sixth clock returns a null bit that must be zero. The last sixteen clocks carry the conversion result, most significant bit first. The block then releases chip select and presents the result for one cycle with a valid strobe.

The serial clock is derived from the system clock. Each half period lasts a parameterised number of system cycles, and the clock rests low. When burst operation is selected for a frame, the block stops the serial clock after every group of eight clocks (8, 8, then 6). It leaves the clock low for a parameterised gap while chip select stays low. A read can therefore be built from byte-sized pieces, the way a host peripheral with a byte-wide shifter would produce it. Chip select is never raised in the middle of a frame, because that would reset the converter's serial port.

Top module: `serial_adc_reader`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, busy, valid and the null-error flag are low, and the result output is zero.
- R2: A start accepted while idle drives chip select low and busy high in the same cycle. Exactly 22 rising serial clock edges follow before chip select rises again, and busy equals the inverse of chip select throughout the frame.
- R3: The serial clock is low whenever chip select is high. Every high phase and every regular low phase lasts HALF_DIV system cycles, and the first rising edge comes HALF_DIV cycles after chip select falls.
- R4: The line values seen on rising edges 1 to 5 have no effect on the result or on the null-error flag.
- R5: The line value seen on rising edge 6 is the null bit. With the valid strobe, the null-error flag goes to 1 if that bit was 1 and to 0 if it was 0. The flag holds its value until the next valid strobe.
- R6: The line values seen on rising edges 7 to 22 form the result, the first of them being bit 15. The result appears with the valid strobe and holds until the next valid strobe.
- R7: Chip select stays low from its falling edge until HALF_DIV cycles after the last falling serial clock edge of the frame. It rises in the same cycle as a valid strobe that lasts exactly one cycle.
- R8: With burst operation, after rising edges 8 and 16 the low phase of the serial clock lasts GAP_CYC + HALF_DIV cycles instead of HALF_DIV, and chip select stays low. Without it, no low phase inside the frame is stretched.
- R9: A start request during a frame, or during the recovery period after it, is ignored and starts no second frame.
- R10: After each frame, chip select stays high for at least REST_CYC cycles, starting with the valid cycle, before the next frame can begin.
- R11: The burst selection is taken at the accepted start. Changing burst_en_i during a frame does not alter that frame's clock pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request one read frame |
| burst_en_i | input | 1 | Split the frame into 8/8/6 clock groups with idle gaps |
| miso_i | input | 1 | Serial data from the converter |
| sclk_o | output | 1 | Serial clock to the converter, rests low |
| cs_n_o | output | 1 | Active-low chip select |
| busy_o | output | 1 | High while a frame is in progress |
| valid_o | output | 1 | One-cycle strobe marking a new result |
| data_o | output | DATA_BITS | Last conversion result |
| null_err_o | output | 1 | Null bit of the last frame read as 1 |

## Verification
The hardest case to reach from the ports is a start request that lands in the short recovery window after chip select rises. At that point busy is already low, yet the request must still be refused. The bench covers it in two ways. It raises start in the cycle right after a valid strobe. It also holds start high across several frames, so that the reference model, which keeps its own count of the recovery cycles, must agree with the design on the exact cycle each new frame begins. A burst-selection change in the middle of a frame, with the gap pattern compared cycle by cycle, covers the second hard case: the burst choice must be latched at the start of the frame.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LEAD,
        S_LOW,
        S_HIGH,
        S_GAP,
        S_TAIL,
        S_REST
    } sadc_state_e;

endpackage

// File: rtl/sadc_halfdiv.sv
module sadc_halfdiv #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [W-1:0] LAST = W'(HALF_DIV - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = run_i && (cnt_q == LAST);
        if (!run_i || tick_o) cnt_d = '0;
        else                  cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_half_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
    assert_idle_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> cnt_q == '0);

endmodule

// File: rtl/sadc_seq.sv
module sadc_seq
    import sadc_pkg::*;
#(
    parameter int ACQ_CLKS  = 5,
    parameter int DATA_BITS = 16,
    parameter int BURST_LEN = 8,
    parameter int GAP_CYC   = 6,
    parameter int REST_CYC  = 3,
    parameter int CW        = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          burst_en_i,
    input  logic          tick_i,
    output logic          run_o,
    output logic          sample_o,
    output logic [CW-1:0] idx_o,
    output logic          frame_start_o,
    output logic          finish_o,
    output logic          sclk_o,
    output logic          cs_n_o,
    output logic          busy_o,
    output logic          valid_o
);
    localparam int FRAME = ACQ_CLKS + 1 + DATA_BITS;
    localparam int GW    = $clog2(GAP_CYC + 1);
    localparam int RW    = $clog2(REST_CYC + 1);
    localparam int BW    = $clog2(BURST_LEN + 1);
    localparam logic [CW-1:0] LAST_CLK = CW'(FRAME);
    localparam logic [GW-1:0] GAP_LAST = GW'(GAP_CYC - 1);
    localparam logic [RW-1:0] RST_LAST = RW'(REST_CYC - 1);
    localparam logic [BW-1:0] GRP_LAST = BW'(BURST_LEN);

    typedef struct packed {
        sadc_state_e   state;
        logic [CW-1:0] clk_cnt;
        logic [BW-1:0] grp_cnt;
        logic [GW-1:0] gap_cnt;
        logic [RW-1:0] rest_cnt;
        logic          burst;
        logic          sclk;
        logic          cs_n;
        logic          valid;
    } seq_t;

    seq_t d, q;

    always_comb begin
        d             = q;
        d.valid       = 1'b0;
        sample_o      = 1'b0;
        frame_start_o = 1'b0;
        finish_o      = 1'b0;
        unique case (q.state)
            S_IDLE: begin
                if (start_i) begin
                    d.state       = S_LEAD;
                    d.cs_n        = 1'b0;
                    d.burst       = burst_en_i;
                    d.clk_cnt     = '0;
                    d.grp_cnt     = '0;
                    frame_start_o = 1'b1;
                end
            end
            S_LEAD, S_LOW: begin
                if (tick_i) begin
                    d.state   = S_HIGH;
                    d.sclk    = 1'b1;
                    d.clk_cnt = q.clk_cnt + CW'(1);
                    d.grp_cnt = q.grp_cnt + BW'(1);
                    sample_o  = 1'b1;
                end
            end
            S_HIGH: begin
                if (tick_i) begin
                    d.sclk = 1'b0;
                    if (q.grp_cnt == GRP_LAST) d.grp_cnt = '0;
                    if (q.clk_cnt == LAST_CLK) begin
                        d.state = S_TAIL;
                    end else if (q.burst && q.grp_cnt == GRP_LAST) begin
                        d.state   = S_GAP;
                        d.gap_cnt = '0;
                    end else begin
                        d.state = S_LOW;
                    end
                end
            end
            S_GAP: begin
                if (q.gap_cnt == GAP_LAST) d.state = S_LOW;
                else                       d.gap_cnt = q.gap_cnt + GW'(1);
            end
            S_TAIL: begin
                if (tick_i) begin
                    d.state    = S_REST;
                    d.cs_n     = 1'b1;
                    d.valid    = 1'b1;
                    d.rest_cnt = '0;
                    finish_o   = 1'b1;
                end
            end
            S_REST: begin
                if (q.rest_cnt == RST_LAST) d.state = S_IDLE;
                else                        d.rest_cnt = q.rest_cnt + RW'(1);
            end
            default: d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state    <= S_IDLE;
            q.clk_cnt  <= '0;
            q.grp_cnt  <= '0;
            q.gap_cnt  <= '0;
            q.rest_cnt <= '0;
            q.burst    <= 1'b0;
            q.sclk     <= 1'b0;
            q.cs_n     <= 1'b1;
            q.valid    <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign run_o   = (q.state == S_LEAD) || (q.state == S_LOW) ||
                     (q.state == S_HIGH) || (q.state == S_TAIL);
    assign idx_o   = q.clk_cnt + CW'(1);
    assign sclk_o  = q.sclk;
    assign cs_n_o  = q.cs_n;
    assign busy_o  = (q.state != S_IDLE) && (q.state != S_REST);
    assign valid_o = q.valid;

    logic in_frame, was_in_frame;
    assign in_frame = busy_o;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) was_in_frame <= 1'b0;
        else        was_in_frame <= in_frame;
    end

    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        q.clk_cnt <= LAST_CLK);
    assert_gap_needs_burst_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == S_GAP) |-> (q.burst && !q.cs_n && !q.sclk));
    assert_burst_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_frame && was_in_frame) |-> $stable(q.burst));
    assert_rest_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == S_REST) |=> q.cs_n);
    assert_tail_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == S_TAIL) |-> (q.clk_cnt == LAST_CLK));

endmodule

// File: rtl/sadc_shift.sv
module sadc_shift #(
    parameter int ACQ_CLKS  = 5,
    parameter int DATA_BITS = 16,
    parameter int CW        = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear_i,
    input  logic                 sample_i,
    input  logic [CW-1:0]        idx_i,
    input  logic                 miso_i,
    input  logic                 finish_i,
    output logic [DATA_BITS-1:0] data_o,
    output logic                 nerr_o
);
    localparam int FRAME = ACQ_CLKS + 1 + DATA_BITS;
    localparam logic [CW-1:0] NULL_IDX = CW'(ACQ_CLKS + 1);
    localparam logic [CW-1:0] LAST_IDX = CW'(FRAME);

    typedef struct packed {
        logic [DATA_BITS-1:0] sh;
        logic                 nerr;
        logic [DATA_BITS-1:0] out;
        logic                 out_err;
    } cap_t;

    cap_t d, q;

    always_comb begin
        d = q;
        if (clear_i) begin
            d.sh   = '0;
            d.nerr = 1'b0;
        end else if (sample_i) begin
            if (idx_i == NULL_IDX)     d.nerr = miso_i;
            else if (idx_i > NULL_IDX) d.sh   = {q.sh[DATA_BITS-2:0], miso_i};
        end
        if (finish_i) begin
            d.out     = q.sh;
            d.out_err = q.nerr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign data_o = q.out;
    assign nerr_o = q.out_err;

    assert_idx_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sample_i |-> (idx_i != '0 && idx_i <= LAST_IDX));
    assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !finish_i |=> $stable(q.out) && $stable(q.out_err));

endmodule

// File: rtl/serial_adc_reader.sv
module serial_adc_reader #(
    parameter int HALF_DIV  = 2,
    parameter int GAP_CYC   = 6,
    parameter int REST_CYC  = 3,
    parameter int ACQ_CLKS  = 5,
    parameter int DATA_BITS = 16,
    parameter int BURST_LEN = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 burst_en_i,
    input  logic                 miso_i,
    output logic                 sclk_o,
    output logic                 cs_n_o,
    output logic                 busy_o,
    output logic                 valid_o,
    output logic [DATA_BITS-1:0] data_o,
    output logic                 null_err_o
);
    localparam int FRAME = ACQ_CLKS + 1 + DATA_BITS;
    localparam int CW    = $clog2(FRAME + 1);

    logic          run, tick, sample, frame_start, finish;
    logic [CW-1:0] idx;

    sadc_halfdiv #(.HALF_DIV(HALF_DIV)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .tick_o (tick)
    );

    sadc_seq #(
        .ACQ_CLKS (ACQ_CLKS),
        .DATA_BITS(DATA_BITS),
        .BURST_LEN(BURST_LEN),
        .GAP_CYC  (GAP_CYC),
        .REST_CYC (REST_CYC),
        .CW       (CW)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .burst_en_i   (burst_en_i),
        .tick_i       (tick),
        .run_o        (run),
        .sample_o     (sample),
        .idx_o        (idx),
        .frame_start_o(frame_start),
        .finish_o     (finish),
        .sclk_o       (sclk_o),
        .cs_n_o       (cs_n_o),
        .busy_o       (busy_o),
        .valid_o      (valid_o)
    );

    sadc_shift #(
        .ACQ_CLKS (ACQ_CLKS),
        .DATA_BITS(DATA_BITS),
        .CW       (CW)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (frame_start),
        .sample_i(sample),
        .idx_i   (idx),
        .miso_i  (miso_i),
        .finish_i(finish),
        .data_o  (data_o),
        .nerr_o  (null_err_o)
    );

    assert_cs_rise_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_o) |-> valid_o);
    assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
    assert_sclk_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> !cs_n_o);
    assert_busy_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !cs_n_o);
    assert_cs_min_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_o) |=> cs_n_o);

endmodule

// File: tb/serial_adc_reader_bench.sv
module serial_adc_reader_bench;
    localparam int HALF  = 3;
    localparam int GAP   = 7;
    localparam int REST  = 4;
    localparam int BLEN  = 8;
    localparam int FRAME = 22;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 1'b0, burst = 1'b0, miso = 1'b0;
    logic sclk, cs_n, busy, valid, nerr;
    logic [15:0] data;

    always #5 clk = ~clk;

    serial_adc_reader #(
        .HALF_DIV(HALF), .GAP_CYC(GAP), .REST_CYC(REST),
        .ACQ_CLKS(5), .DATA_BITS(16), .BURST_LEN(BLEN)
    ) u_serial_adc_reader (
        .clk(clk), .rst_n(rst_n), .start_i(start), .burst_en_i(burst),
        .miso_i(miso), .sclk_o(sclk), .cs_n_o(cs_n), .busy_o(busy),
        .valid_o(valid), .data_o(data), .null_err_o(nerr)
    );

    typedef struct packed {
        logic        cs_n;
        logic        sclk;
        logic        valid;
        logic [15:0] word;
        logic        err;
    } exp_t;

    exp_t        exq[$];
    exp_t        cur;
    int          rest_left = 0;
    logic [15:0] hold_word = '0;
    logic        hold_err  = 1'b0;
    int          total = 0, bad = 0, vcount = 0, cycles = 0;
    string       tag = "R1";

    logic [15:0] adc_word = '0;
    logic        adc_null = 1'b0, adc_acq = 1'b0;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s (%s) act=%0h exp=%0h t=%0t", req, tag, act, exp, $time);
        end
    endtask

    function automatic void add(int n, logic s);
        for (int i = 0; i < n; i++) exq.push_back('{1'b0, s, 1'b0, 16'h0, 1'b0});
    endfunction

    function automatic void build(logic b);
        add(HALF, 1'b0);
        for (int k = 1; k <= FRAME; k++) begin
            add(HALF, 1'b1);
            if (k < FRAME) begin
                if (b && (k % BLEN) == 0) add(GAP, 1'b0);
                add(HALF, 1'b0);
            end
        end
        add(HALF, 1'b0);
        exq.push_back('{1'b1, 1'b0, 1'b1, adc_word, adc_null});
    endfunction

    // reference model, advanced at each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            exq.delete();
            cur       = '{1'b1, 1'b0, 1'b0, 16'h0, 1'b0};
            rest_left = 0;
        end else begin
            if (exq.size() == 0 && rest_left == 0 && start) build(burst);
            if (exq.size() > 0) begin
                cur = exq.pop_front();
                if (cur.valid) begin
                    rest_left = REST;
                    hold_word = cur.word;
                    hold_err  = cur.err;
                end
            end else begin
                if (rest_left > 0) rest_left--;
                cur = '{1'b1, 1'b0, 1'b0, 16'h0, 1'b0};
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R3", 32'(sclk), 32'(cur.sclk));
            chk("R7", 32'(cs_n), 32'(cur.cs_n));
            chk("R2", 32'(busy), 32'(!cur.cs_n));
            chk("R7", 32'(valid), 32'(cur.valid));
            chk("R6", 32'(data), 32'(hold_word));
            chk("R5", 32'(nerr), 32'(hold_err));
            if (valid) vcount++;
        end
    end

    // converter model: new bit after chip select falls and after each falling serial edge
    logic sclk_prev = 1'b0, cs_prev = 1'b1;
    int   nb = 0, rises = 0, hi_cnt = 0;
    logic seen_frame = 1'b0;

    function automatic logic bitval(int n);
        if (n <= 5)  return adc_acq;
        if (n == 6)  return adc_null;
        if (n <= 22) return adc_word[22-n];
        return 1'b0;
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            if (!cs_n && sclk && !sclk_prev) rises++;
            if (cs_n && !cs_prev) begin
                chk("R2", 32'(rises), 32'(FRAME));
                rises = 0;
            end
            if (cs_n) hi_cnt++;
            if (!cs_n && cs_prev) begin
                if (seen_frame) begin
                    total++;
                    if (hi_cnt < REST) begin
                        bad++;
                        $display("FAIL R10 (%s) act=%0d exp>=%0d", tag, hi_cnt, REST);
                    end
                end
                seen_frame = 1'b1;
                hi_cnt = 0;
            end
            if (cs_n) nb = 0;
            else if (cs_prev || (sclk_prev && !sclk)) begin
                nb++;
                miso = bitval(nb);
            end
            sclk_prev = sclk;
            cs_prev   = cs_n;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wait_idle();
        @(negedge clk);
        while (!(exq.size() == 0 && rest_left == 0 && cs_n)) @(negedge clk);
    endtask

    task automatic frame(logic [15:0] w, logic nul, logic acq, logic b, string t);
        int v0;
        wait_idle();
        tag = t; adc_word = w; adc_null = nul; adc_acq = acq; burst = b;
        v0 = vcount;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (vcount == v0) @(negedge clk);
    endtask

    initial begin
        int v0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        tag = "R1";
        chk("R1", 32'(cs_n), 32'd1);
        chk("R1", 32'(sclk), 32'd0);
        chk("R1", 32'(busy), 32'd0);
        chk("R1", 32'(valid), 32'd0);
        chk("R1", 32'(data), 32'd0);
        chk("R1", 32'(nerr), 32'd0);

        frame(16'hA5C3, 1'b0, 1'b0, 1'b0, "R6");
        frame(16'hFFFF, 1'b0, 1'b1, 1'b0, "R4");
        frame(16'h0000, 1'b0, 1'b1, 1'b0, "R4");
        frame(16'h8001, 1'b1, 1'b0, 1'b0, "R5");
        frame(16'h7FFE, 1'b0, 1'b1, 1'b0, "R5");
        frame(16'h1234, 1'b0, 1'b0, 1'b1, "R8");
        frame(16'hC0DE, 1'b1, 1'b1, 1'b1, "R8");

        // burst selection changed in the middle of a frame (R11)
        wait_idle();
        tag = "R11"; adc_word = 16'h5A5A; adc_null = 1'b0; burst = 1'b0;
        v0 = vcount;
        start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (10) @(negedge clk);
        burst = 1'b1;
        while (vcount == v0) @(negedge clk);
        burst = 1'b0;

        // start during a frame and during recovery (R9)
        wait_idle();
        tag = "R9"; adc_word = 16'h0F0F;
        v0 = vcount;
        start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (40) @(negedge clk);
        start = 1'b1; @(negedge clk); start = 1'b0;
        while (vcount == v0) @(negedge clk);
        start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (30) @(negedge clk);
        chk("R9", 32'(vcount - v0), 32'd1);
        chk("R9", 32'(cs_n), 32'd1);

        // start held high: frames back to back with minimum recovery (R10)
        wait_idle();
        tag = "R10"; adc_word = 16'h3C96;
        v0 = vcount;
        start = 1'b1;
        while (vcount < v0 + 3) @(negedge clk);
        start = 1'b0;
        wait_idle();
        chk("R10", 32'(vcount - v0), 32'd3);

        repeat (5) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule